// File: doc/BRIEF.md
# Fixed-Timeline Simultaneous ADC Sequencer

This controller drives a multi-channel simultaneous-sampling SAR converter at a fixed frame rate. Each frame begins with one conversion-start strobe that reaches every channel pair at the same moment. The controller then waits a fixed, worst-case number of controller clocks and reads all channels back over a serial port. The converter's conversion clock is asynchronous to the controller. Because of this, one channel pair can latch the strobe one conversion clock later than another pair. Its finish pulse on the shared busy line then arrives later too. Starting the readout at the first busy fall would return the previous frame's value for the late pair. Starting it after a fixed delay avoids that. There is only a minimum wait before reading and no maximum, so the worst-case schedule is always legal.

The busy line never gates the data path. It passes through a two-flop synchronizer and is watched for two faults: it is still high when the readout starts, or it never rose early in the frame. The default parameters assume a 100 MHz controller clock and give a 250-cycle (2.5 µs) frame:
- The conversion wait is 150 cycles, which covers the worst-case conversion plus one extra converter clock.
- Four data lanes, one per channel pair, each shift 32 bits at a 50 MHz serial clock.

Top module: `adc_frame_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is applied, the outputs are idle: conv_start_o low, cs_n_o high, sclk_o low, samples_valid_o low, and all three error flags low.
- R2: conv_start_o is high for exactly START_W cycles at the start of every FRAME_CYC-cycle frame. The first frame's strobe rises at the first clock edge after reset is released.
- R3: cs_n_o falls exactly CONV_WAIT+1 cycles after conv_start_o rises.
- R4: While cs_n_o is low, sclk_o toggles every SCLK_HALF cycles starting low, with LANE_BITS = (CHANNELS/LANES)*WORD_W rising edges per readout. sdi_i is sampled on each rising edge, MSB first. sclk_o is low whenever cs_n_o is high.
- R5: Lane l carries channels l*CPL to l*CPL+CPL-1 in that order, where CPL = CHANNELS/LANES. Channel c appears on samples_o[c*WORD_W +: WORD_W].
- R6: samples_valid_o is a one-cycle pulse in the same cycle that cs_n_o returns high, 2*LANE_BITS*SCLK_HALF cycles after cs_n_o fell. samples_o holds its value until the next pulse.
- R7: busy_i has no effect on when conversion starts, when readout starts, or on the sample data returned.
- R8: busy_err_late_o sets one cycle after the readout launch cycle if busy_i, delayed by the two-flop synchronizer, is still high in that cycle. It stays set until reset.
- R9: busy_err_miss_o sets if the synchronized busy signal shows no rising edge within frame cycles 0..BUSY_WIN. It stays set until reset.
- R10: overrun_o sets one cycle after a frame boundary that arrives while a readout is still in progress. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start_o | output | 1 | Shared conversion-start strobe to all channel pairs |
| busy_i | input | 1 | Converter busy line, asynchronous |
| cs_n_o | output | 1 | Serial chip select, active low |
| sclk_o | output | 1 | Serial clock, idle low |
| sdi_i | input | LANES | Serial data, one lane per channel pair |
| samples_o | output | CHANNELS*WORD_W | All channel words from the latest readout |
| samples_valid_o | output | 1 | One-cycle strobe when samples_o updates |
| busy_err_late_o | output | 1 | Sticky: busy still high at readout launch |
| busy_err_miss_o | output | 1 | Sticky: busy did not rise within the window |
| overrun_o | output | 1 | Sticky: frame boundary during a readout |

## Verification
Cycles are numbered from reset release: cycle n follows the n-th clock edge, and frame counter value n-1 applies in that cycle. With that numbering:
- The strobe is due in cycles 1..START_W of each frame.
- Chip select falls in cycle CONV_WAIT+2.
- The valid pulse lands in cycle CONV_WAIT+2+2*LANE_BITS*SCLK_HALF.
- Each sticky flag shows one cycle after the cycle that caused it. The busy line adds two cycles of synchronizer delay before that.

The bench records the cycle number of every output change at the falling clock edge and compares it against these formulas. It also checks the words, rise count and flags at the end of each frame. One directed case counts overrun cycles on a second instance whose frame is too short for its readout.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  // serial bits that each data lane carries per frame
  function automatic int lane_bits(input int channels, input int lanes, input int word_w);
    return (channels / lanes) * word_w;
  endfunction

  // controller cycles from chip-select fall to chip-select rise
  function automatic int read_cycles(input int bits, input int sclk_half);
    return 2 * bits * sclk_half;
  endfunction

  // frame cycle in which the readout completes (launch at conv_wait)
  function automatic int finish_cycle(input int conv_wait, input int bits, input int sclk_half);
    return conv_wait + 1 + read_cycles(bits, sclk_half);
  endfunction

  // true when a readout completes before the next frame boundary
  function automatic bit schedule_fits(input int frame_cyc, input int conv_wait,
                                       input int bits, input int sclk_half);
    return finish_cycle(conv_wait, bits, sclk_half) < frame_cyc;
  endfunction

endpackage

// File: rtl/adcseq_frame_timer.sv
module adcseq_frame_timer #(
  parameter int FRAME_CYC = 250,
  parameter int START_W   = 3,
  parameter int CONV_WAIT = 150,
  parameter int FCW       = $clog2(FRAME_CYC)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [FCW-1:0] fcnt_o,
  output logic           frame_tick_o,
  output logic           launch_o,
  output logic           start_o
);
  localparam logic [FCW-1:0] LAST  = FCW'(FRAME_CYC - 1);
  localparam logic [FCW-1:0] SW    = FCW'(START_W);
  localparam logic [FCW-1:0] LAUNCH = FCW'(CONV_WAIT);

  logic [FCW-1:0] fcnt_nxt;

  assign fcnt_nxt = (fcnt_o == LAST) ? '0 : fcnt_o + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_o  <= LAST;
      start_o <= 1'b0;
    end else begin
      fcnt_o  <= fcnt_nxt;
      start_o <= (fcnt_nxt < SW);
    end
  end

  assign frame_tick_o = (fcnt_o == '0);
  assign launch_o     = (fcnt_o == LAUNCH);

  assert_start_frame_edge_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(start_o) |-> frame_tick_o);

  assert_start_width_R2: assert property (@(posedge clk) disable iff (rst)
    (start_o && fcnt_o == SW - 1'b1) |=> !start_o);

endmodule

// File: rtl/adcseq_reader.sv
module adcseq_reader #(
  parameter int LANES     = 4,
  parameter int LANE_BITS = 32,
  parameter int SCLK_HALF = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       go_i,
  input  logic [LANES-1:0]           sdi_i,
  output logic                       cs_n_o,
  output logic                       sclk_o,
  output logic                       reading_o,
  output logic                       fin_o,
  output logic [LANES*LANE_BITS-1:0] lanes_o
);
  localparam int HCW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BCW = $clog2(LANE_BITS + 1);

  logic           active;
  logic [HCW-1:0] hcnt;
  logic [BCW-1:0] bcnt;
  logic           half_end;
  logic           rise_ev;
  logic           fall_ev;

  assign half_end  = active && (hcnt == HCW'(SCLK_HALF - 1));
  assign rise_ev   = half_end && !sclk_o;
  assign fall_ev   = half_end && sclk_o;
  assign fin_o     = fall_ev && (bcnt == BCW'(LANE_BITS - 1));
  assign reading_o = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cs_n_o <= 1'b1;
      sclk_o <= 1'b0;
      hcnt   <= '0;
      bcnt   <= '0;
    end else if (!active) begin
      if (go_i) begin
        active <= 1'b1;
        cs_n_o <= 1'b0;
        sclk_o <= 1'b0;
        hcnt   <= '0;
        bcnt   <= '0;
      end
    end else if (half_end) begin
      hcnt   <= '0;
      sclk_o <= ~sclk_o;
      if (fall_ev) bcnt <= bcnt + 1'b1;
      if (fin_o) begin
        active <= 1'b0;
        cs_n_o <= 1'b1;
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst)          sh <= '0;
      else if (rise_ev) sh <= {sh[LANE_BITS-2:0], sdi_i[g]};
    end
    assign lanes_o[g*LANE_BITS +: LANE_BITS] = sh;
  end

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  assert_go_ignored_while_reading_R4: assert property (@(posedge clk) disable iff (rst)
    (active && !fin_o) |=> !cs_n_o);

endmodule

// File: rtl/adcseq_busy_monitor.sv
module adcseq_busy_monitor #(
  parameter int FCW      = 8,
  parameter int BUSY_WIN = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           busy_i,
  input  logic [FCW-1:0] fcnt_i,
  input  logic           frame_tick_i,
  input  logic           launch_i,
  output logic           late_err_o,
  output logic           miss_err_o
);
  logic s1, s2, s3;
  logic busy_rise;
  logic seen;
  logic win_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= busy_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign busy_rise = s2 && !s3;
  assign win_end   = (fcnt_i == FCW'(BUSY_WIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      seen       <= 1'b0;
      late_err_o <= 1'b0;
      miss_err_o <= 1'b0;
    end else begin
      seen <= frame_tick_i ? busy_rise : (seen | busy_rise);
      if (launch_i && s2)                    late_err_o <= 1'b1;
      if (win_end && !seen && !busy_rise)    miss_err_o <= 1'b1;
    end
  end

  assert_late_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    late_err_o |=> late_err_o);

  assert_miss_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    miss_err_o |=> miss_err_o);

  assert_late_needs_launch_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(late_err_o) |-> $past(launch_i));

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
  parameter int CHANNELS  = 8,
  parameter int LANES     = 4,
  parameter int WORD_W    = 16,
  parameter int FRAME_CYC = 250,
  parameter int START_W   = 3,
  parameter int CONV_WAIT = 150,
  parameter int SCLK_HALF = 1,
  parameter int BUSY_WIN  = 40
) (
  input  logic                       clk,
  input  logic                       rst,
  output logic                       conv_start_o,
  input  logic                       busy_i,
  output logic                       cs_n_o,
  output logic                       sclk_o,
  input  logic [LANES-1:0]           sdi_i,
  output logic [CHANNELS*WORD_W-1:0] samples_o,
  output logic                       samples_valid_o,
  output logic                       busy_err_late_o,
  output logic                       busy_err_miss_o,
  output logic                       overrun_o
);
  import adcseq_pkg::*;

  localparam int FCW = $clog2(FRAME_CYC);
  localparam int CPL = CHANNELS / LANES;
  localparam int LB  = lane_bits(CHANNELS, LANES, WORD_W);

  logic [FCW-1:0]          fcnt;
  logic                    frame_tick;
  logic                    launch;
  logic                    reading;
  logic                    fin;
  logic [LANES*LB-1:0]     lanes;
  logic [CHANNELS*WORD_W-1:0] mapped;

  adcseq_frame_timer #(
    .FRAME_CYC(FRAME_CYC), .START_W(START_W), .CONV_WAIT(CONV_WAIT), .FCW(FCW)
  ) u_timer (
    .clk(clk), .rst(rst), .fcnt_o(fcnt), .frame_tick_o(frame_tick),
    .launch_o(launch), .start_o(conv_start_o)
  );

  adcseq_reader #(
    .LANES(LANES), .LANE_BITS(LB), .SCLK_HALF(SCLK_HALF)
  ) u_reader (
    .clk(clk), .rst(rst), .go_i(launch), .sdi_i(sdi_i), .cs_n_o(cs_n_o),
    .sclk_o(sclk_o), .reading_o(reading), .fin_o(fin), .lanes_o(lanes)
  );

  adcseq_busy_monitor #(
    .FCW(FCW), .BUSY_WIN(BUSY_WIN)
  ) u_busy (
    .clk(clk), .rst(rst), .busy_i(busy_i), .fcnt_i(fcnt),
    .frame_tick_i(frame_tick), .launch_i(launch),
    .late_err_o(busy_err_late_o), .miss_err_o(busy_err_miss_o)
  );

  // first word shifted on a lane is the lowest channel of that lane
  for (genvar l = 0; l < LANES; l++) begin : g_map_lane
    for (genvar j = 0; j < CPL; j++) begin : g_map_word
      assign mapped[(l*CPL + j)*WORD_W +: WORD_W] = lanes[l*LB + (CPL-1-j)*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      samples_o       <= '0;
      samples_valid_o <= 1'b0;
      overrun_o       <= 1'b0;
    end else begin
      samples_valid_o <= fin;
      if (fin) samples_o <= mapped;
      if (frame_tick && reading) overrun_o <= 1'b1;
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    samples_valid_o |=> !samples_valid_o);

  assert_valid_with_cs_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> samples_valid_o);

  assert_samples_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !samples_valid_o |-> $stable(samples_o));

  assert_launch_opens_read_R7: assert property (@(posedge clk) disable iff (rst)
    (launch && !reading) |=> !cs_n_o);

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);

endmodule

// File: tb/tb_adc_frame_seq.sv
module tb_adc_frame_seq;
  localparam int BF    = 100;   // frame cycles
  localparam int BSW   = 3;     // start width
  localparam int BCW   = 20;    // conversion wait
  localparam int BH    = 1;     // sclk half period
  localparam int BWIN  = 10;    // busy window
  localparam int LBITS = 32;    // bits per lane
  localparam int EXP_CS    = BCW + 2;
  localparam int EXP_VALID = EXP_CS + 2 * LBITS * BH;
  localparam int OVR_FRAME = 60;

  // {mode[1:0], seed[15:0], exp_late, exp_miss}
  // mode 0 normal pulses, 1 never rises, 2 stays high, 3 rises late
  localparam logic [19:0] VECS [0:4] = '{
    {2'd0, 16'hA5C3, 1'b0, 1'b0},
    {2'd1, 16'h1E0F, 1'b0, 1'b1},
    {2'd2, 16'h7B21, 1'b1, 1'b0},
    {2'd3, 16'hC04D, 1'b0, 1'b1},
    {2'd0, 16'hFFFF, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy = 1'b0;
  logic [3:0] sdi;
  logic conv_start, cs_n, sclk, valid, late, miss, ovr;
  logic [127:0] samples;
  logic o_start, o_cs_n, o_sclk, o_valid, o_late, o_miss, o_ovr;
  logic [127:0] o_samples;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [15:0] cur_seed = 16'h0;
  logic [31:0] lane_sh [0:3];
  bit in_read = 1'b0;

  int obs_cs_fall, obs_valid, obs_rises, obs_start_early, obs_start_late;
  bit obs_hold_ok;
  logic [127:0] obs_samples;

  always #10 clk = ~clk;

  adc_frame_seq #(
    .FRAME_CYC(BF), .START_W(BSW), .CONV_WAIT(BCW), .SCLK_HALF(BH), .BUSY_WIN(BWIN)
  ) dut (
    .clk(clk), .rst(rst), .conv_start_o(conv_start), .busy_i(busy), .cs_n_o(cs_n),
    .sclk_o(sclk), .sdi_i(sdi), .samples_o(samples), .samples_valid_o(valid),
    .busy_err_late_o(late), .busy_err_miss_o(miss), .overrun_o(ovr)
  );

  adc_frame_seq #(
    .FRAME_CYC(OVR_FRAME), .START_W(BSW), .CONV_WAIT(BCW), .SCLK_HALF(BH), .BUSY_WIN(BWIN)
  ) dut_ovr (
    .clk(clk), .rst(rst), .conv_start_o(o_start), .busy_i(busy), .cs_n_o(o_cs_n),
    .sclk_o(o_sclk), .sdi_i(4'b0000), .samples_o(o_samples), .samples_valid_o(o_valid),
    .busy_err_late_o(o_late), .busy_err_miss_o(o_miss), .overrun_o(o_ovr)
  );

  function automatic logic [15:0] word_of(input logic [15:0] seed, input int c);
    return (seed ^ 16'(16'h1357 * (c + 1))) + 16'(c * 3);
  endfunction

  function automatic logic busy_level(input int mode, input int f);
    case (mode)
      0: return (f >= 2 && f <= 9) || f == 11 || f == 13 || f == 15;
      1: return 1'b0;
      2: return f >= 2;
      default: return f >= 12 && f <= 15;
    endcase
  endfunction

  // converter model: first bit present at chip-select fall, next bit after each sclk fall
  always @(negedge sclk or negedge cs_n or posedge cs_n) begin
    if (cs_n) begin
      in_read = 1'b0;
    end else if (!in_read) begin
      in_read = 1'b1;
      for (int l = 0; l < 4; l++)
        lane_sh[l] = {word_of(cur_seed, 2*l), word_of(cur_seed, 2*l + 1)};
    end else begin
      for (int l = 0; l < 4; l++) lane_sh[l] = {lane_sh[l][30:0], 1'b0};
    end
  end

  assign sdi = {lane_sh[3][31], lane_sh[2][31], lane_sh[1][31], lane_sh[0][31]};

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    busy = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // called in cycle 0 of a frame (just after a falling edge)
  task automatic run_frame(input int mode);
    logic prev_cs, prev_sclk;
    prev_cs = cs_n;
    prev_sclk = sclk;
    obs_cs_fall = -1; obs_valid = -1; obs_rises = 0;
    obs_start_early = 0; obs_start_late = 0; obs_hold_ok = 1'b1;
    for (int n = 1; n <= BF; n++) begin
      @(negedge clk);
      if (prev_cs && !cs_n) obs_cs_fall = n;
      if (!prev_sclk && sclk) obs_rises++;
      if (n <= BSW) obs_start_early += int'(conv_start);
      else          obs_start_late  += int'(conv_start);
      if (valid) begin
        obs_valid = n;
        obs_samples = samples;
      end else if (obs_valid > 0 && samples != obs_samples) begin
        obs_hold_ok = 1'b0;
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
      busy = busy_level(mode, n - 1);
    end
  endtask

  task automatic check_words(input string tag, input logic [15:0] seed);
    bit ok;
    logic [15:0] a, e;
    ok = 1'b1; a = '0; e = '0;
    for (int c = 0; c < 8; c++) begin
      if (ok && obs_samples[c*16 +: 16] != word_of(seed, c)) begin
        ok = 1'b0;
        a = obs_samples[c*16 +: 16];
        e = word_of(seed, c);
      end
    end
    check(tag, ok, a, e);
  endtask

  initial begin
    do_reset();
    // R1: idle after reset
    check("R1 start idle", conv_start == 1'b0, conv_start, 0);
    check("R1 cs idle", cs_n == 1'b1, cs_n, 1);
    check("R1 sclk idle", sclk == 1'b0, sclk, 0);
    check("R1 flags idle", {valid, late, miss, ovr} == 4'b0, {valid, late, miss, ovr}, 0);

    for (int v = 0; v < 5; v++) begin
      int mode;
      logic [15:0] seed;
      mode = int'(VECS[v][19:18]);
      seed = VECS[v][17:2];
      if (v > 0) do_reset();
      cur_seed = seed;
      run_frame(mode);
      check($sformatf("R2 start width v%0d", v), obs_start_early == BSW, obs_start_early, BSW);
      check($sformatf("R2 start low rest v%0d", v), obs_start_late == 0, obs_start_late, 0);
      check($sformatf("R3 cs fall cycle v%0d", v), obs_cs_fall == EXP_CS, obs_cs_fall, EXP_CS);
      check($sformatf("R4 sclk rises v%0d", v), obs_rises == LBITS, obs_rises, LBITS);
      check($sformatf("R6 valid cycle v%0d", v), obs_valid == EXP_VALID, obs_valid, EXP_VALID);
      check($sformatf("R6 samples held v%0d", v), obs_hold_ok, obs_hold_ok, 1);
      check_words($sformatf("R5 channel words v%0d", v), seed);
      if (mode != 0)
        check($sformatf("R7 busy mode %0d timing", mode),
              obs_cs_fall == EXP_CS && obs_valid == EXP_VALID, obs_valid, EXP_VALID);
      check($sformatf("R8 late flag v%0d", v), late == VECS[v][1], late, VECS[v][1]);
      check($sformatf("R9 miss flag v%0d", v), miss == VECS[v][0], miss, VECS[v][0]);
      check($sformatf("R10 no overrun v%0d", v), ovr == 1'b0, ovr, 0);
    end

    // R8 sticky across a clean frame, R2 second frame, R7 data unaffected
    do_reset();
    cur_seed = 16'h3C96;
    run_frame(2);
    cur_seed = 16'h0001;
    run_frame(0);
    check("R8 late stays set", late == 1'b1, late, 1);
    check("R2 second frame start", obs_start_early == BSW, obs_start_early, BSW);
    check_words("R7 second frame words", 16'h0001);

    // R1: reset applied in the middle of a readout
    repeat (40) @(negedge clk);
    check("R3 reading before reset", cs_n == 1'b0, cs_n, 0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-read reset cs/sclk", cs_n == 1'b1 && sclk == 1'b0, {cs_n, sclk}, 2'b10);
    check("R1 mid-read reset flags", {conv_start, valid, late, miss} == 4'b0,
          {conv_start, valid, late, miss}, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R10: short-frame instance, boundary during readout in cycle 61
    for (int n = 1; n <= 62; n++) begin
      @(negedge clk);
      busy = busy_level(0, (n - 1) % OVR_FRAME);
      if (n == 61) check("R10 overrun not before boundary", o_ovr == 1'b0, o_ovr, 0);
      if (n == 62) check("R10 overrun after boundary", o_ovr == 1'b1, o_ovr, 1);
    end
    check("R10 main instance no overrun", ovr == 1'b0, ovr, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule